// File: doc/BRIEF.md
# Configurable Serial Audio Receiver

This block turns a three-wire stereo PCM stream into parallel sample words. A bit clock, a word clock and a serial data line arrive from an external audio source. All three are brought into the system clock domain by two-flop synchronisers, and each rising edge of the bit clock is found by edge detection. Each rising edge of the bit clock takes one data bit. The word clock tells the two channels apart. Samples are two's complement and are sent most significant bit first.

Three static configuration inputs set how the stream is framed. The first chooses between right-justified framing, where a word ends on the bit just before the word-clock transition, and I2S framing, where a word starts one bit after the transition. The second sets the word length to 16, 20 or 24 bits. The third selects which level of the word clock marks the left channel. Once both words of a stereo pair have been taken in, the block presents them as sign-extended 24-bit values and pulses a strobe. A separate detector counts consecutive zero bits on the data line and raises a flag after a long unbroken run.

Top module: `pcm_serial_rx`

## Requirements
- R1: While reset is asserted and after it is released, with no stream applied, `leftWord` and `rightWord` are zero and `pairValid` and `zeroFlag` are low.
- R2: `cfgLenSel` selects the word length: 2'b00 gives 16 bits, 2'b01 gives 20 bits, 2'b10 gives 24 bits, and the reserved code 2'b11 acts as 24 bits. A shorter word is sign-extended from its own top bit into the 24-bit output.
- R3: With `cfgI2s` low (right-justified), a channel's word is the last N bits sampled before the word-clock transition that ends that channel's half. Earlier bits in the half have no effect on the output.
- R4: With `cfgI2s` high (I2S), the most significant bit is sampled on the second rising bit-clock edge after a word-clock transition, and the next N-1 bits follow it. The first bit after the transition, and any bits after the least significant bit, have no effect on the output.
- R5: With `cfgSwapLr` low, a high word clock marks the left channel and a low word clock marks the right channel. With `cfgSwapLr` high, the mapping is reversed.
- R6: When a right word completes after a left word, `pairValid` is high for exactly one clock. In that clock `leftWord` and `rightWord` hold that pair.
- R7: A right word that completes with no left word captured since reset or since the last pair is dropped. It produces no strobe, so each left-then-right pair gives exactly one strobe.
- R8: `zeroFlag` goes high once ZERO_RUN consecutive sampled data bits have been zero (the default for ZERO_RUN is 65,536). It stays high while further zero bits arrive.
- R9: A sampled data bit of one clears the zero run. If `zeroFlag` was high, it drops on the next clock.
- R10: The bit clock, word clock and data line are taken through two-flop synchronisers. Each rising bit-clock edge gives exactly one sample, provided the bit clock stays high for at least two system clocks and low for at least two system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| bitClk | input | 1 | Serial bit clock (asynchronous) |
| wordClk | input | 1 | Word clock selecting the channel (asynchronous) |
| dataIn | input | 1 | Serial audio data (asynchronous) |
| cfgI2s | input | 1 | 0: right-justified framing, 1: I2S framing |
| cfgLenSel | input | 2 | Word length code (see R2) |
| cfgSwapLr | input | 1 | Reverses the word-clock channel polarity |
| leftWord | output | 24 | Last left sample, sign-extended |
| rightWord | output | 24 | Last right sample, sign-extended |
| pairValid | output | 1 | One-clock strobe for a completed stereo pair |
| zeroFlag | output | 1 | Long run of zero data bits detected |

## Verification
The bench runs every combination of framing, word length (including the reserved code) and polarity. Each combination gets frames carrying the most negative value, the most positive value, minus one, one, and mixed patterns. The padding bits around each word are filled with non-zero junk. If the capture window is off by one bit, the values come out doubled or halved. If the design reads the padding, junk bits show up in the output. A polarity error makes the left and right words trade places. The first word-clock edge after reset closes a right word that has no left partner, so a design that pairs it anyway gives an extra strobe. The zero detector is taken to one bit short of its threshold and then exactly to it, and a single one bit then checks that the flag clears at once.

// File: rtl/pcm_rx_pkg.sv
package pcm_rx_pkg;

  localparam int WORD_W = 24;

  // Strobes from the control unit to the datapath
  typedef struct packed {
    logic shift;     // take one data bit
    logic usePre;    // capture the word before this bit is shifted in
    logic capLeft;   // capture completes a left word
    logic capRight;  // capture completes a right word
  } rxStrobe_t;

  function automatic logic [5:0] rxLenBits(input logic [1:0] lenSel);
    case (lenSel)
      2'b00:   return 6'd16;
      2'b01:   return 6'd20;
      default: return 6'd24;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] rxSignExtend(input logic [WORD_W-1:0] raw,
                                                     input logic [1:0] lenSel);
    case (lenSel)
      2'b00:   return {{(WORD_W-16){raw[15]}}, raw[15:0]};
      2'b01:   return {{(WORD_W-20){raw[19]}}, raw[19:0]};
      default: return raw;
    endcase
  endfunction

  function automatic logic rxSignOk(input logic [WORD_W-1:0] word,
                                    input logic [1:0] lenSel);
    case (lenSel)
      2'b00:   return (&word[WORD_W-1:15]) || !(|word[WORD_W-1:15]);
      2'b01:   return (&word[WORD_W-1:19]) || !(|word[WORD_W-1:19]);
      default: return 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/pcm_rx_sync.sv
module pcm_rx_sync #(
  parameter int STAGES = 2,
  parameter int LANES  = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LANES-1:0] asyncIn,
  output logic [LANES-1:1] levelOut,
  output logic             rise0
);

  logic [LANES-1:0] pipe [STAGES];
  logic             lastLane0;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : gStage
      if (g == 0) begin : gFirst
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) pipe[g] <= '0;
          else       pipe[g] <= asyncIn;
        end
      end else begin : gNext
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) pipe[g] <= '0;
          else       pipe[g] <= pipe[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lastLane0 <= 1'b0;
    else       lastLane0 <= pipe[STAGES-1][0];
  end

  assign levelOut = pipe[STAGES-1][LANES-1:1];
  assign rise0    = pipe[STAGES-1][0] && !lastLane0;

endmodule

// File: rtl/pcm_rx_ctrl.sv
module pcm_rx_ctrl
  import pcm_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitRise,
  input  logic       wcS,
  input  logic       cfgI2s,
  input  logic [1:0] cfgLenSel,
  input  logic       cfgSwapLr,
  output rxStrobe_t  ctl
);

  localparam logic [5:0] IDX_MAX = 6'h3F;

  logic       primed;
  logic       wcPrev;
  logic [5:0] bitIdx;
  logic [5:0] thisIdx;
  logic [5:0] lenBits;
  logic       wcEdge;
  logic       capAny;
  logic       capIsLeft;

  always_comb begin
    lenBits   = rxLenBits(cfgLenSel);
    wcEdge    = bitRise && primed && (wcS != wcPrev);
    if (wcEdge)                thisIdx = 6'd0;
    else if (bitIdx == IDX_MAX) thisIdx = bitIdx;
    else                       thisIdx = bitIdx + 6'd1;

    if (cfgI2s) begin
      // word runs from index 1 to index N after a transition
      capAny    = bitRise && primed && (thisIdx == lenBits);
      capIsLeft = wcS ^ cfgSwapLr;
    end else begin
      // word closes at the transition and belongs to the previous level
      capAny    = wcEdge;
      capIsLeft = wcPrev ^ cfgSwapLr;
    end

    ctl.shift    = bitRise;
    ctl.usePre   = !cfgI2s;
    ctl.capLeft  = capAny && capIsLeft;
    ctl.capRight = capAny && !capIsLeft;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      primed <= 1'b0;
      wcPrev <= 1'b0;
      bitIdx <= IDX_MAX;
    end else if (bitRise) begin
      primed <= 1'b1;
      wcPrev <= wcS;
      bitIdx <= thisIdx;
    end
  end

  // captures are spaced by whole bit periods
  assert_capture_spacing_R10: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.capLeft || ctl.capRight) |=> !(ctl.capLeft || ctl.capRight));

endmodule

// File: rtl/pcm_rx_datapath.sv
module pcm_rx_datapath
  import pcm_rx_pkg::*;
#(
  parameter int ZERO_RUN = 65536
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxStrobe_t         ctl,
  input  logic              dataS,
  input  logic [1:0]        cfgLenSel,
  output logic [WORD_W-1:0] leftWord,
  output logic [WORD_W-1:0] rightWord,
  output logic              pairValid,
  output logic              zeroFlag
);

  localparam int             CNT_W   = $clog2(ZERO_RUN + 1);
  localparam logic [CNT_W-1:0] RUN_END = CNT_W'(ZERO_RUN);

  logic [WORD_W-1:0] shiftReg;
  logic [WORD_W-1:0] shiftNext;
  logic [WORD_W-1:0] capSrc;
  logic [WORD_W-1:0] capWord;
  logic              haveLeft;
  logic [CNT_W-1:0]  zeroCnt;

  assign shiftNext = {shiftReg[WORD_W-2:0], dataS};
  assign capSrc    = ctl.usePre ? shiftReg : shiftNext;
  assign capWord   = rxSignExtend(capSrc, cfgLenSel);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg  <= '0;
      leftWord  <= '0;
      rightWord <= '0;
      pairValid <= 1'b0;
      haveLeft  <= 1'b0;
    end else begin
      pairValid <= 1'b0;
      if (ctl.shift) shiftReg <= shiftNext;
      if (ctl.capLeft) begin
        leftWord <= capWord;
        haveLeft <= 1'b1;
      end
      if (ctl.capRight && haveLeft) begin
        rightWord <= capWord;
        pairValid <= 1'b1;
        haveLeft  <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      zeroCnt <= '0;
    end else if (ctl.shift) begin
      if (dataS)                 zeroCnt <= '0;
      else if (zeroCnt != RUN_END) zeroCnt <= zeroCnt + 1'b1;
    end
  end

  assign zeroFlag = (zeroCnt == RUN_END);

  assert_valid_single_R6: assert property (@(posedge clk) disable iff (!rstN)
    pairValid |=> !pairValid);

  assert_sign_extend_R2: assert property (@(posedge clk) disable iff (!rstN)
    pairValid |-> (rxSignOk(leftWord, cfgLenSel) && rxSignOk(rightWord, cfgLenSel)));

  assert_zero_rise_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(zeroFlag) |-> $past(ctl.shift && !dataS));

  assert_zero_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.shift && dataS) |=> !zeroFlag);

endmodule

// File: rtl/pcm_serial_rx.sv
module pcm_serial_rx
  import pcm_rx_pkg::*;
#(
  parameter int ZERO_RUN    = 65536,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitClk,
  input  logic              wordClk,
  input  logic              dataIn,
  input  logic              cfgI2s,
  input  logic [1:0]        cfgLenSel,
  input  logic              cfgSwapLr,
  output logic [WORD_W-1:0] leftWord,
  output logic [WORD_W-1:0] rightWord,
  output logic              pairValid,
  output logic              zeroFlag
);

  logic [2:1] lvl;
  logic       bitRise;
  rxStrobe_t  ctl;

  pcm_rx_sync #(.STAGES(SYNC_STAGES), .LANES(3)) i_sync (
    .clk      (clk),
    .rstN     (rstN),
    .asyncIn  ({dataIn, wordClk, bitClk}),
    .levelOut (lvl),
    .rise0    (bitRise)
  );

  pcm_rx_ctrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .bitRise   (bitRise),
    .wcS       (lvl[1]),
    .cfgI2s    (cfgI2s),
    .cfgLenSel (cfgLenSel),
    .cfgSwapLr (cfgSwapLr),
    .ctl       (ctl)
  );

  pcm_rx_datapath #(.ZERO_RUN(ZERO_RUN)) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .dataS     (lvl[2]),
    .cfgLenSel (cfgLenSel),
    .leftWord  (leftWord),
    .rightWord (rightWord),
    .pairValid (pairValid),
    .zeroFlag  (zeroFlag)
  );

endmodule

// File: tb/test_pcm_serial_rx.sv
`timescale 1ns/1ps
module test_pcm_serial_rx;

  localparam int RUN  = 100;
  localparam int SLOT = 32;
  localparam int NFR  = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bitClk = 1'b0, wordClk = 1'b0, dataIn = 1'b0;
  logic cfgI2s = 1'b0, cfgSwapLr = 1'b0;
  logic [1:0] cfgLenSel = 2'b00;
  logic [23:0] leftWord, rightWord;
  logic pairValid, zeroFlag;

  int nChecks = 0;
  int nFails  = 0;
  int gotN    = 0;
  logic [23:0] gotL [128];
  logic [23:0] gotR [128];

  always #4 clk = ~clk;

  pcm_serial_rx #(.ZERO_RUN(RUN)) i_pcm_serial_rx (
    .clk(clk), .rstN(rstN), .bitClk(bitClk), .wordClk(wordClk), .dataIn(dataIn),
    .cfgI2s(cfgI2s), .cfgLenSel(cfgLenSel), .cfgSwapLr(cfgSwapLr),
    .leftWord(leftWord), .rightWord(rightWord), .pairValid(pairValid), .zeroFlag(zeroFlag)
  );

  always @(negedge clk) begin
    if (rstN && pairValid && gotN < 128) begin
      gotL[gotN] = leftWord;
      gotR[gotN] = rightWord;
      gotN = gotN + 1;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    $display("FAIL watchdog: run did not complete (actual hung, expected done)");
    nFails++;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic sendBit(input logic w, input logic d);
    @(negedge clk); wordClk = w; dataIn = d; bitClk = 1'b0;
    @(negedge clk); bitClk = 1'b1;
    @(negedge clk);
    @(negedge clk); bitClk = 1'b0;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    bitClk = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    // R1: reset state
    check("R1 reset outputs", {4'd0, leftWord | rightWord, pairValid, zeroFlag, 2'b00}, 32'd0);
  endtask

  function automatic int lenOf(input int code);
    return (code == 0) ? 16 : (code == 1) ? 20 : 24;
  endfunction

  function automatic int rawVal(input int cfg, input int f, input int ch, input int n);
    int mask = (1 << n) - 1;
    int v;
    case (f)
      0: v = (ch == 0) ? (1 << (n-1)) : ((1 << (n-1)) - 1);
      1: v = (ch == 0) ? ((1 << (n-1)) - 1) : (1 << (n-1));
      2: v = (ch == 0) ? mask : 1;
      default: v = cfg * 32'h13579B + ch * 32'h2468AC + 32'h05A5A5;
    endcase
    return v & mask;
  endfunction

  function automatic logic [23:0] expOf(input int raw, input int n);
    int r = raw;
    if (((r >> (n-1)) & 1) == 1) r = r | ~((1 << n) - 1);
    return r[23:0];
  endfunction

  task automatic sendSlot(input logic lvl, input int raw, input int n, input logic i2s);
    for (int i = 0; i < SLOT; i++) begin
      logic b;
      b = ((i * 7) % 3 == 0);  // padding junk
      if (!i2s && i >= SLOT - n) b = ((raw >> (SLOT - 1 - i)) & 1) == 1;
      if (i2s && i >= 1 && i <= n) b = ((raw >> (n - i)) & 1) == 1;
      sendBit(lvl, b);
    end
  endtask

  initial begin
    for (int c = 0; c < 16; c++) begin
      int n, base;
      logic lLvl;
      string mtag;
      cfgI2s    = c[3];
      cfgSwapLr = c[2];
      cfgLenSel = c[1:0];   // includes reserved code 11 (R2)
      n    = lenOf(c & 3);
      lLvl = ~cfgSwapLr;    // R5: left level of the word clock
      mtag = cfgI2s ? "R4" : "R3";
      doReset();
      base = gotN;
      sendBit(~lLvl, 1'b0);
      for (int f = 0; f < NFR; f++) begin
        sendSlot(lLvl,  rawVal(c, f, 0, n), n, cfgI2s);
        sendSlot(~lLvl, rawVal(c, f, 1, n), n, cfgI2s);
      end
      sendBit(lLvl, 1'b0);
      repeat (6) @(negedge clk);
      // R6 and R7: one strobe per pair, orphan right word dropped
      check($sformatf("R6 R7 pair count cfg %0d", c), gotN - base, NFR);
      for (int f = 0; f < NFR; f++) begin
        check($sformatf("%s R5 R2 left cfg %0d frame %0d", mtag, c, f),
              {8'd0, gotL[base + f]}, {8'd0, expOf(rawVal(c, f, 0, n), n)});
        check($sformatf("%s R5 R2 right cfg %0d frame %0d", mtag, c, f),
              {8'd0, gotR[base + f]}, {8'd0, expOf(rawVal(c, f, 1, n), n)});
      end
    end

    // zero-run detector
    cfgI2s = 1'b0; cfgSwapLr = 1'b0; cfgLenSel = 2'b00;
    doReset();
    for (int i = 0; i < RUN - 1; i++) sendBit(1'b1, 1'b0);
    repeat (3) @(negedge clk);
    check("R8 one bit short of run", {31'd0, zeroFlag}, 32'd0);
    sendBit(1'b1, 1'b0);
    repeat (3) @(negedge clk);
    check("R8 run reached", {31'd0, zeroFlag}, 32'd1);
    for (int i = 0; i < 20; i++) sendBit(1'b0, 1'b0);
    repeat (3) @(negedge clk);
    check("R8 flag holds during zeros", {31'd0, zeroFlag}, 32'd1);
    sendBit(1'b0, 1'b1);
    repeat (3) @(negedge clk);
    check("R9 one bit clears flag", {31'd0, zeroFlag}, 32'd0);
    for (int i = 0; i < RUN - 1; i++) sendBit(1'b0, 1'b0);
    repeat (3) @(negedge clk);
    check("R9 run restarted from zero", {31'd0, zeroFlag}, 32'd0);
    sendBit(1'b0, 1'b0);
    repeat (3) @(negedge clk);
    check("R8 R10 rerun reached", {31'd0, zeroFlag}, 32'd1);

    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule